// File: doc/BRIEF.md
# Layered MLP Feedforward Sequencer

This block evaluates a small multilayer perceptron one layer at a time. A fixed group of multiply-accumulate lanes is reused for every layer. Weights and biases sit in on-chip storage that is filled through a write port and then frozen. Each run latches an observation vector, walks the hidden layers in order with a rectifier on every neuron, then evaluates the output layer with no activation. Results go into an internal result register.

The action vector only reaches the output port when a fetch command arrives. A fetch issued together with the start gives blocking use. A start followed later by a fetch gives non-blocking use, where the caller does other work while the block computes. The output-valid flag is the indication the caller polls. The folding factor `FOLD` divides the lane count. It trades multiplier count for cycles and does not change the numeric result.

Arithmetic is signed Q8.8 (16 bit) with a 32-bit accumulator per lane. Bias is added after the products, then the sum is shifted back to Q8.8 (floor) and saturated to 16 bits.

Top module: `mlp_seq_top`

## Requirements
- R1: After reset, `busy`, `actValid` and `paramsReady` are 0 and `actVec` is all zeros.
- R2: Writes on the parameter port take effect only before `ldSeal` has been pulsed. After the seal, `paramsReady` stays 1 and further writes change no result.
- R3: A `startReq` while `paramsReady` is 0 is ignored: `busy` stays 0.
- R4: A neuron's value is floor((bias*256 + sum of weight*input) / 256), saturated to the range -32768..32767. All values are Q8.8 two's complement.
- R5: Hidden-layer values below zero are replaced by 0. Output-layer values keep their sign.
- R6: With `ldBias`=0, a weight sits at address base(L) + n*in(L) + k, where base(L) is the sum of in*out over the earlier layers. With `ldBias`=1, a bias sits at the sum of out over the earlier layers plus n. Observation i and action j are bits [16i+15:16i] of `obsVec` and `actVec`.
- R7: An accepted start raises `busy` for exactly the sum over layers of ceil(out/LANES)*(in+1) cycles, where LANES = ceil(widest neuron layer / FOLD).
- R8: A `startReq` while `busy` is 1 is ignored and does not change the running computation.
- R9: An accepted start clears `actValid` on the next cycle. `actVec` and `actValid` update only after a fetch: a fetch issued while busy, or together with the start, is remembered and published one cycle after `busy` falls. A fetch in idle with a result ready publishes on the next cycle.
- R10: A `fetchReq` while idle with no result available is ignored.
- R11: Results are identical for every `FOLD` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Parameter write strobe |
| ldBias | input | 1 | 1 selects bias storage, 0 selects weight storage |
| ldAddr | input | LDAW | Parameter write address |
| ldData | input | 16 | Parameter value, Q8.8 |
| ldSeal | input | 1 | Ends the preload phase and freezes the parameters |
| obsVec | input | NUM_IN*16 | Observation vector, latched on an accepted start |
| startReq | input | 1 | Start a feedforward run |
| fetchReq | input | 1 | Request publication of the latest result |
| actVec | output | NUM_OUT*16 | Published action vector |
| actValid | output | 1 | Published actions are valid |
| busy | output | 1 | A run is in progress |
| paramsReady | output | 1 | Preload has been sealed |

## Verification
Random weights, biases and observations are run through two instances, with `FOLD` set to 1 and to 4. Every clock, their flags and actions are compared with a behavioural model. The model predicts each instance's own busy window, so a wrong group count or an off-by-one input loop shows up as a timing mismatch, while an addressing error shows up as a value mismatch.

Directed parameter sets separate three behaviours: all-negative first-layer sums tell a missing rectifier apart from a correct one, large weights drive both saturation limits, and a write after the seal shows whether the freeze holds. Ordering patterns cover these cases:
- fetch issued with the start;
- fetch issued mid-run;
- fetch issued long after completion;
- a second start issued mid-run;
- early start and fetch issued before the seal.

// File: rtl/mlp_seq_pkg.sv
package mlp_seq_pkg;

  localparam int unsigned MAX_HID = 5;

  // strobes and indices from control to datapath
  typedef struct packed {
    logic        latchObs;
    logic        accClr;
    logic        macEn;
    logic        laneWr;
    logic        outLayer;
    logic        publish;
    logic        rdSel;
    logic [7:0]  kIdx;
    logic [7:0]  nBase;
    logic [7:0]  inCnt;
    logic [7:0]  outCnt;
    logic [15:0] wBase;
    logic [7:0]  bBase;
  } seq_ctl_t;

  // width of vector idx: 0 = observations, 1..nHid = hidden, above = actions
  function automatic int unsigned widthOf(input logic [39:0] hidW, input int unsigned nHid,
                                          input int unsigned nIn, input int unsigned nOut,
                                          input int unsigned idx);
    if (idx == 0) return nIn;
    if (idx > nHid) return nOut;
    return {24'd0, hidW[8*(idx-1) +: 8]};
  endfunction

  function automatic int unsigned weightBase(input logic [39:0] hidW, input int unsigned nHid,
                                             input int unsigned nIn, input int unsigned nOut,
                                             input int unsigned layer);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < MAX_HID + 1; j++)
      if (j < layer) s += widthOf(hidW, nHid, nIn, nOut, j) * widthOf(hidW, nHid, nIn, nOut, j + 1);
    return s;
  endfunction

  function automatic int unsigned biasBase(input logic [39:0] hidW, input int unsigned nHid,
                                           input int unsigned nIn, input int unsigned nOut,
                                           input int unsigned layer);
    int unsigned s;
    s = 0;
    for (int unsigned j = 0; j < MAX_HID + 1; j++)
      if (j < layer) s += widthOf(hidW, nHid, nIn, nOut, j + 1);
    return s;
  endfunction

  function automatic int unsigned maxWidth(input logic [39:0] hidW, input int unsigned nHid,
                                           input int unsigned nIn, input int unsigned nOut,
                                           input int unsigned firstIdx);
    int unsigned m;
    m = 1;
    for (int unsigned j = 0; j < MAX_HID + 2; j++)
      if (j >= firstIdx && j <= nHid + 1 && widthOf(hidW, nHid, nIn, nOut, j) > m)
        m = widthOf(hidW, nHid, nIn, nOut, j);
    return m;
  endfunction

  function automatic logic signed [15:0] sat16(input logic signed [39:0] v);
    if (v > 40'sd32767) return 16'sh7fff;
    if (v < -40'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction

endpackage

// File: rtl/mlp_seq_ctrl.sv
module mlp_seq_ctrl
  import mlp_seq_pkg::*;
#(
  parameter int unsigned NUM_IN     = 4,
  parameter int unsigned NUM_HID    = 2,
  parameter logic [39:0] HID_WIDTHS = 40'h00_00_00_05_08,
  parameter int unsigned NUM_OUT    = 3,
  parameter int unsigned LANES      = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ldSeal,
  input  logic     startReq,
  input  logic     fetchReq,
  output seq_ctl_t ctl,
  output logic     busy,
  output logic     paramsReady,
  output logic     actValid
);

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_WB} seq_state_t;

  seq_state_t  state;
  logic [2:0]  layer;
  logic [7:0]  grp;
  logic [7:0]  k;
  logic        resReady;
  logic        pending;

  int unsigned curIn, curOut, nBase, layerI;
  logic        lastK, lastGrp, lastLayer, startOk, doPublish;

  always_comb begin
    layerI    = {29'd0, layer};
    curIn     = widthOf(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, layerI);
    curOut    = widthOf(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, layerI + 1);
    nBase     = {24'd0, grp} * LANES;
    lastK     = ({24'd0, k} + 1) >= curIn;
    lastGrp   = (nBase + LANES) >= curOut;
    lastLayer = layerI == NUM_HID;
    startOk   = startReq && paramsReady && (state == S_IDLE);
    doPublish = (state == S_IDLE) && !startOk && resReady && (fetchReq || pending);

    ctl.latchObs = startOk;
    ctl.accClr   = startOk || (state == S_WB);
    ctl.macEn    = state == S_MAC;
    ctl.laneWr   = state == S_WB;
    ctl.outLayer = lastLayer;
    ctl.publish  = doPublish;
    ctl.rdSel    = layer[0];
    ctl.kIdx     = k;
    ctl.nBase    = 8'(nBase);
    ctl.inCnt    = 8'(curIn);
    ctl.outCnt   = 8'(curOut);
    ctl.wBase    = 16'(weightBase(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, layerI));
    ctl.bBase    = 8'(biasBase(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, layerI));
  end

  assign busy = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      layer       <= '0;
      grp         <= '0;
      k           <= '0;
      resReady    <= 1'b0;
      pending     <= 1'b0;
      paramsReady <= 1'b0;
      actValid    <= 1'b0;
    end else begin
      if (ldSeal) paramsReady <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (startOk) begin
            state    <= S_MAC;
            layer    <= '0;
            grp      <= '0;
            k        <= '0;
            resReady <= 1'b0;
            actValid <= 1'b0;
            pending  <= fetchReq;
          end else if (doPublish) begin
            actValid <= 1'b1;
            pending  <= 1'b0;
          end
        end
        S_MAC: begin
          if (fetchReq) pending <= 1'b1;
          if (lastK) state <= S_WB;
          else k <= k + 8'd1;
        end
        default: begin
          if (fetchReq) pending <= 1'b1;
          k <= '0;
          if (lastGrp) begin
            grp <= '0;
            if (lastLayer) begin
              state    <= S_IDLE;
              resReady <= 1'b1;
            end else begin
              layer <= layer + 3'd1;
              state <= S_MAC;
            end
          end else begin
            grp   <= grp + 8'd1;
            state <= S_MAC;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mlp_seq_dp.sv
module mlp_seq_dp
  import mlp_seq_pkg::*;
#(
  parameter int unsigned NUM_IN  = 4,
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned LANES   = 8,
  parameter int unsigned MAXW    = 8,
  parameter int unsigned WTOT    = 87,
  parameter int unsigned BTOT    = 16,
  parameter int unsigned LDAW    = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seq_ctl_t                 ctl,
  input  logic                     sealed,
  input  logic                     ldEn,
  input  logic                     ldBias,
  input  logic [LDAW-1:0]          ldAddr,
  input  logic [15:0]              ldData,
  input  logic [NUM_IN*16-1:0]     obsVec,
  output logic [NUM_OUT*16-1:0]    actVec
);

  localparam int WAW = (WTOT > 1) ? $clog2(WTOT) : 1;
  localparam int BAW = (BTOT > 1) ? $clog2(BTOT) : 1;
  localparam int XAW = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam int OAW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;

  logic signed [15:0] wMem   [WTOT];
  logic signed [15:0] bMem   [BTOT];
  logic signed [15:0] actBuf [2][MAXW];
  logic signed [15:0] resReg [NUM_OUT];

  logic signed [15:0]    xCur;
  logic [LANES-1:0]      laneOn;
  logic [LANES*16-1:0]   laneVal;
  logic [LANES*8-1:0]    laneN;

  assign xCur = actBuf[ctl.rdSel][XAW'(ctl.kIdx)];

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [15:0]        nIdx, wIdx, bIdx;
    logic               on;
    logic signed [15:0] wVal, bVal, satV;
    logic signed [31:0] prod, acc;
    logic signed [39:0] sum40;

    always_comb begin
      nIdx  = 16'(ctl.nBase) + 16'(l);
      on    = nIdx < 16'(ctl.outCnt);
      wIdx  = ctl.wBase + nIdx * 16'(ctl.inCnt) + 16'(ctl.kIdx);
      bIdx  = 16'(ctl.bBase) + nIdx;
      wVal  = (on && wIdx < 16'(WTOT)) ? wMem[WAW'(wIdx)] : 16'sd0;
      bVal  = (on && bIdx < 16'(BTOT)) ? bMem[BAW'(bIdx)] : 16'sd0;
      prod  = 32'(wVal) * 32'(xCur);
      sum40 = 40'(acc) + (40'(bVal) <<< 8);
      satV  = sat16(sum40 >>> 8);
    end

    assign laneOn[l]          = on;
    assign laneN[8*l +: 8]    = nIdx[7:0];
    assign laneVal[16*l +: 16] = (!ctl.outLayer && satV < 0) ? 16'sd0 : satV;

    always_ff @(posedge clk) begin
      if (!rstN || ctl.accClr) acc <= '0;
      else if (ctl.macEn) acc <= acc + prod;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WTOT; i++) wMem[i] <= '0;
      for (int i = 0; i < BTOT; i++) bMem[i] <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < MAXW; i++) actBuf[b][i] <= '0;
      for (int o = 0; o < NUM_OUT; o++) resReg[o] <= '0;
      actVec <= '0;
    end else begin
      if (ldEn && !sealed) begin
        if (ldBias) begin
          if (32'(ldAddr) < BTOT) bMem[BAW'(ldAddr)] <= ldData;
        end else begin
          if (32'(ldAddr) < WTOT) wMem[WAW'(ldAddr)] <= ldData;
        end
      end
      if (ctl.latchObs)
        for (int i = 0; i < NUM_IN; i++) actBuf[0][i] <= obsVec[16*i +: 16];
      if (ctl.laneWr)
        for (int l = 0; l < LANES; l++)
          if (laneOn[l]) begin
            if (ctl.outLayer) resReg[OAW'(laneN[8*l +: 8])] <= laneVal[16*l +: 16];
            else actBuf[!ctl.rdSel][XAW'(laneN[8*l +: 8])] <= laneVal[16*l +: 16];
          end
      if (ctl.publish)
        for (int o = 0; o < NUM_OUT; o++) actVec[16*o +: 16] <= resReg[o];
    end
  end

endmodule

// File: rtl/mlp_seq_top.sv
module mlp_seq_top
  import mlp_seq_pkg::*;
#(
  parameter int unsigned NUM_IN     = 4,
  parameter int unsigned NUM_HID    = 2,
  parameter logic [39:0] HID_WIDTHS = 40'h00_00_00_05_08,
  parameter int unsigned NUM_OUT    = 3,
  parameter int unsigned FOLD       = 1,
  localparam int unsigned MAXN = maxWidth(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, 1),
  localparam int unsigned MAXW = maxWidth(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, 0),
  localparam int unsigned LANES = (MAXN + FOLD - 1) / FOLD,
  localparam int unsigned WTOT = weightBase(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, NUM_HID + 1),
  localparam int unsigned BTOT = biasBase(HID_WIDTHS, NUM_HID, NUM_IN, NUM_OUT, NUM_HID + 1),
  localparam int unsigned LDAW = $clog2((WTOT > BTOT) ? WTOT : BTOT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ldEn,
  input  logic                  ldBias,
  input  logic [LDAW-1:0]       ldAddr,
  input  logic [15:0]           ldData,
  input  logic                  ldSeal,
  input  logic [NUM_IN*16-1:0]  obsVec,
  input  logic                  startReq,
  input  logic                  fetchReq,
  output logic [NUM_OUT*16-1:0] actVec,
  output logic                  actValid,
  output logic                  busy,
  output logic                  paramsReady
);

  seq_ctl_t ctl;

  mlp_seq_ctrl #(
    .NUM_IN(NUM_IN), .NUM_HID(NUM_HID), .HID_WIDTHS(HID_WIDTHS),
    .NUM_OUT(NUM_OUT), .LANES(LANES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ldSeal(ldSeal), .startReq(startReq), .fetchReq(fetchReq),
    .ctl(ctl), .busy(busy), .paramsReady(paramsReady), .actValid(actValid)
  );

  mlp_seq_dp #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .LANES(LANES), .MAXW(MAXW),
    .WTOT(WTOT), .BTOT(BTOT), .LDAW(LDAW)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sealed(paramsReady), .ldEn(ldEn), .ldBias(ldBias),
    .ldAddr(ldAddr), .ldData(ldData), .obsVec(obsVec), .actVec(actVec)
  );

endmodule

// File: rtl/mlp_seq_chk.sv
module mlp_seq_chk #(
  parameter int unsigned NUM_OUT = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startReq,
  input logic                  busy,
  input logic                  paramsReady,
  input logic                  actValid,
  input logic [NUM_OUT*16-1:0] actVec
);

  a_r2_seal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    paramsReady |=> paramsReady);

  a_r3_start_needs_seal: assert property (@(posedge clk) disable iff (!rstN)
    !paramsReady |=> !busy);

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq && paramsReady));

  a_r9_valid_clears: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && paramsReady && !busy) |=> !actValid);

  a_r9_valid_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    actValid |-> !busy);

  a_r9_actions_hold: assert property (@(posedge clk) disable iff (!rstN)
    (actValid && $past(actValid)) |-> $stable(actVec));

endmodule

bind mlp_seq_top mlp_seq_chk #(.NUM_OUT(NUM_OUT)) uChk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .paramsReady(paramsReady), .actValid(actValid), .actVec(actVec)
);

// File: tb/tb_mlp_seq_top.sv
module tb_mlp_seq_top;

  localparam int NI = 4;
  localparam int NH = 2;
  localparam int NO = 3;
  localparam logic [39:0] HW = {8'd0, 8'd0, 8'd0, 8'd5, 8'd8};
  localparam int WT = 87;
  localparam int BT = 16;
  localparam int AW = 7;
  localparam int WID [4] = '{4, 8, 5, 3};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldEn = 0, ldBias = 0, ldSeal = 0, startReq = 0, fetchReq = 0;
  logic [AW-1:0] ldAddr = '0;
  logic [15:0] ldData = '0;
  logic [NI*16-1:0] obsVec = '0;

  logic [NO*16-1:0] actA, actB;
  logic validA, validB, busyA, busyB, readyA, readyB;

  always #2.5 clk = ~clk;

  mlp_seq_top #(.NUM_IN(NI), .NUM_HID(NH), .HID_WIDTHS(HW), .NUM_OUT(NO), .FOLD(1)) dut (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldBias(ldBias), .ldAddr(ldAddr), .ldData(ldData),
    .ldSeal(ldSeal), .obsVec(obsVec), .startReq(startReq), .fetchReq(fetchReq),
    .actVec(actA), .actValid(validA), .busy(busyA), .paramsReady(readyA));

  mlp_seq_top #(.NUM_IN(NI), .NUM_HID(NH), .HID_WIDTHS(HW), .NUM_OUT(NO), .FOLD(4)) dutF4 (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldBias(ldBias), .ldAddr(ldAddr), .ldData(ldData),
    .ldSeal(ldSeal), .obsVec(obsVec), .startReq(startReq), .fetchReq(fetchReq),
    .actVec(actB), .actValid(validB), .busy(busyB), .paramsReady(readyB));

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string curTag = "R1";

  int wRef [WT];
  int bRef [BT];
  int refOut [NO];

  // behavioural model state, index 0 = FOLD 1, index 1 = FOLD 4
  int mLeft [2];
  bit mReady [2], mPend [2], mValid [2], mSealed;
  int mRes [2][NO];
  int mAct [2][NO];
  int lat [2];

  function automatic int latency(int lanes);
    int s = 0;
    for (int L = 0; L <= NH; L++) s += ((WID[L+1] + lanes - 1) / lanes) * (WID[L] + 1);
    return s;
  endfunction

  function automatic int satI(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic void computeRef(logic [NI*16-1:0] ov);
    int cur [8];
    int nxt [8];
    int wb = 0, bb = 0;
    for (int i = 0; i < NI; i++) cur[i] = int'($signed(ov[16*i +: 16]));
    for (int L = 0; L <= NH; L++) begin
      for (int n = 0; n < WID[L+1]; n++) begin
        longint s = longint'(bRef[bb + n]) * 256;
        for (int k = 0; k < WID[L]; k++) s += longint'(wRef[wb + n*WID[L] + k]) * cur[k];
        nxt[n] = satI(s >>> 8);
        if (L < NH && nxt[n] < 0) nxt[n] = 0;
      end
      wb += WID[L] * WID[L+1];
      bb += WID[L+1];
      for (int n = 0; n < 8; n++) cur[n] = nxt[n];
    end
    for (int o = 0; o < NO; o++) refOut[o] = cur[o];
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin
    lat[0] = latency(8);
    lat[1] = latency(2);
  end

  // model advances on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mSealed = 0;
      for (int d = 0; d < 2; d++) begin
        mLeft[d] = 0; mReady[d] = 0; mPend[d] = 0; mValid[d] = 0;
        for (int o = 0; o < NO; o++) begin mAct[d][o] = 0; mRes[d][o] = 0; end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (mLeft[d] > 0) begin
          if (fetchReq) mPend[d] = 1;
          mLeft[d]--;
          if (mLeft[d] == 0) mReady[d] = 1;
        end else if (startReq && mSealed) begin
          computeRef(obsVec);
          mLeft[d] = lat[d];
          mReady[d] = 0;
          mValid[d] = 0;
          mPend[d] = fetchReq;
          for (int o = 0; o < NO; o++) mRes[d][o] = refOut[o];
        end else if (mReady[d] && (fetchReq || mPend[d])) begin
          mValid[d] = 1;
          mPend[d] = 0;
          for (int o = 0; o < NO; o++) mAct[d][o] = mRes[d][o];
        end
      end
      if (ldSeal) mSealed = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R7", "busy f1", busyA, mLeft[0] > 0);
      chk("R7", "busy f4", busyB, mLeft[1] > 0);
      chk("R2", "paramsReady f1", readyA, mSealed);
      chk("R2", "paramsReady f4", readyB, mSealed);
      chk(curTag, "actValid f1", validA, mValid[0]);
      chk(curTag, "actValid f4", validB, mValid[1]);
      for (int o = 0; o < NO; o++) begin
        chk({curTag, "/R4"}, "action f1", $signed(actA[16*o +: 16]), mAct[0][o]);
        chk({curTag, "/R11"}, "action f4", $signed(actB[16*o +: 16]), mAct[1][o]);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic loadOne(bit isBias, int addr, int val);
    @(negedge clk);
    ldEn = 1; ldBias = isBias; ldAddr = AW'(addr); ldData = 16'(val);
    if (!mSealed) begin
      if (isBias) bRef[addr] = val; else wRef[addr] = val;
    end
    @(negedge clk);
    ldEn = 0;
  endtask

  task automatic pulse(bit st, bit fe);
    @(negedge clk);
    startReq = st; fetchReq = fe;
    @(negedge clk);
    startReq = 0; fetchReq = 0;
  endtask

  task automatic seal();
    @(negedge clk); ldSeal = 1;
    @(negedge clk); ldSeal = 0;
  endtask

  task automatic waitValid();
    for (int i = 0; i < 200 && !(validA && validB); i++) @(negedge clk);
  endtask

  task automatic randObs();
    for (int i = 0; i < NI; i++) obsVec[16*i +: 16] = 16'(int'($urandom_range(0, 1023)) - 512);
  endtask

  initial begin
    doReset();
    curTag = "R1";
    @(negedge clk);
    chk("R1", "busy after reset", busyA | busyB, 0);
    chk("R1", "actValid after reset", validA | validB, 0);
    chk("R1", "paramsReady after reset", readyA | readyB, 0);
    chk("R1", "actions after reset", actA | actB, 0);

    curTag = "R3";
    randObs();
    pulse(1, 0);
    repeat (3) @(negedge clk);
    chk("R3", "busy on unsealed start", busyA | busyB, 0);

    curTag = "R10";
    pulse(0, 1);
    @(negedge clk);
    chk("R10", "fetch with no result", validA | validB, 0);

    curTag = "R6";
    for (int a = 0; a < WT; a++) loadOne(0, a, int'($urandom_range(0, 255)) - 128);
    for (int a = 0; a < BT; a++) loadOne(1, a, int'($urandom_range(0, 511)) - 256);
    seal();

    curTag = "R2";
    loadOne(0, 0, 16'h7f00);
    loadOne(1, 13, 16'h4000);
    chk("R2", "sealed flag", readyA & readyB, 1);

    curTag = "R10";
    pulse(0, 1);
    @(negedge clk);
    chk("R10", "fetch before first run", validA | validB, 0);

    curTag = "R4";
    for (int r = 0; r < 4; r++) begin
      randObs();
      pulse(1, 1);
      waitValid();
      computeRef(obsVec);
      for (int o = 0; o < NO; o++) begin
        chk("R4", "blocking action f1", $signed(actA[16*o +: 16]), refOut[o]);
        chk("R11", "blocking action f4", $signed(actB[16*o +: 16]), refOut[o]);
      end
    end

    curTag = "R9";
    randObs();
    pulse(1, 0);
    repeat (5) @(negedge clk);
    chk("R9", "valid cleared by start", validA | validB, 0);
    pulse(0, 1);
    waitValid();
    chk("R9", "mid-run fetch published", validA & validB, 1);
    randObs();
    pulse(1, 0);
    repeat (80) @(negedge clk);
    chk("R9", "result withheld until fetch", validA | validB, 0);
    pulse(0, 1);
    chk("R9", "late fetch published", validA & validB, 1);

    curTag = "R8";
    randObs();
    computeRef(obsVec);
    pulse(1, 1);
    repeat (3) @(negedge clk);
    randObs();
    pulse(1, 0);
    waitValid();
    for (int o = 0; o < NO; o++)
      chk("R8", "second start ignored", $signed(actB[16*o +: 16]), refOut[o]);

    // rectifier and linear output
    curTag = "R5";
    doReset();
    for (int a = 0; a < WT; a++) loadOne(0, a, (a < 32) ? -256 : 256);
    for (int a = 0; a < BT; a++) loadOne(1, a, (a >= 8 && a < 13) ? 256 : ((a >= 13) ? -2048 : 0));
    seal();
    for (int i = 0; i < NI; i++) obsVec[16*i +: 16] = 16'd256;
    pulse(1, 1);
    waitValid();
    for (int o = 0; o < NO; o++) begin
      chk("R5", "rectified hidden, linear output f1", $signed(actA[16*o +: 16]), -768);
      chk("R5", "rectified hidden, linear output f4", $signed(actB[16*o +: 16]), -768);
    end

    // saturation in both directions
    curTag = "R4";
    doReset();
    for (int a = 0; a < WT; a++) loadOne(0, a, (a < 32) ? 32512 : ((a < 72 || a < 77) ? 256 : -256));
    for (int a = 0; a < BT; a++) loadOne(1, a, 0);
    seal();
    for (int i = 0; i < NI; i++) obsVec[16*i +: 16] = 16'd1024;
    pulse(1, 1);
    waitValid();
    chk("R4", "positive saturation f1", $signed(actA[15:0]), 32767);
    chk("R4", "negative saturation f1", $signed(actA[31:16]), -32768);
    chk("R11", "saturation f4", $signed(actB[47:32]), -32768);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule